// File: doc/BRIEF.md
# EEPROM Page Write Buffer Controller

This block sits between the serial bus front end of a small EEPROM and its memory array. It handles the write side of the device. After a start condition and a word address, it takes data bytes from the bus front end into a page buffer of 16 bytes. Each byte lands at the current in-page offset, and the block records which slots have been filled. Nothing reaches the array until the stop condition that closes the transfer.

At that stop the block checks the write-protect level. If writes are permitted and at least one byte is held, it opens a self-timed write window. The window lasts a programmable number of system clocks and stands in for the nominal 3 ms program time. During the first cycles of the window the loaded slots are written to the array one per clock, in ascending offset order. Each write simply overwrites the old byte. For the whole window `busy_o` is high, so the front end stops acknowledging and every bus-side input is ignored.

The data input is a valid/ready stream. A byte moves on a cycle where `in_valid_i` and `in_ready_o` are both high. `in_ready_o` is high only while a transfer is addressed and no write window runs. A source that sees `in_ready_o` low must hold its byte. The start, address-load and stop inputs are single-cycle pulses. The array port has no back-pressure: the array takes every strobe in the cycle it is issued.

Top module: `eeprom_page_commit`

## Requirements
- R1: After reset `busy_o`, `in_ready_o` and `mem_we_o` are all 0.
- R2: `in_ready_o` is 1 only after a start pulse followed by an address load; between a start and its address load, and while idle, it is 0 and offered bytes are dropped.
- R3: No array write happens while bytes are being collected; `mem_we_o` is 0 until the transfer's stop pulse has been taken.
- R4: A stop that finds at least one buffered byte with `wp_i` = 0 raises `busy_o` from the next cycle for exactly WRITE_CYCLES cycles. In window cycle i (i counted from 0, i < 16), slot i is written if it was loaded, at address {page, i} where page is address bits 10:4.
- R5: The in-page offset (address bits 3:0) steps by one per accepted byte and wraps from 15 to 0, while bits 10:4 stay fixed. A byte sent to an offset already loaded replaces the earlier one.
- R6: Only slots loaded during the current transfer are written. A start pulse, including a repeated start, clears every slot flag, so bytes from an abandoned transfer are never written.
- R7: `wp_i` is sampled at the stop pulse. A level of 1 discards the buffer with no write and no busy window. A level of 0, which is also the level the board pull-down gives an open pin, permits the commit. The level before the stop and during the window has no effect.
- R8: A stop that ends a transfer with no data byte (address only, or no address) starts no write window.
- R9: While `busy_o` is 1, `in_ready_o` is 0 and the start, address-load and stop pulses are ignored. After the window the block is idle and needs a new start before it takes an address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start condition seen on the bus (pulse) |
| addr_load_i | input | 1 | Word address received (pulse) |
| addr_i | input | ADDR_W | Starting byte address, bits 10:4 page, 3:0 offset |
| in_valid_i | input | 1 | Data byte offered |
| in_ready_o | output | 1 | Data byte can be taken this cycle |
| in_data_i | input | DATA_W | Data byte |
| stop_i | input | 1 | Stop condition seen on the bus (pulse) |
| wp_i | input | 1 | Write-protect level, 1 blocks writes |
| busy_o | output | 1 | Self-timed write window running |
| mem_we_o | output | 1 | Array write strobe |
| mem_addr_o | output | ADDR_W | Array write address |
| mem_wdata_o | output | DATA_W | Array write data |

## Verification
The assertions assume that in any one cycle at most one of `start_i`, `addr_load_i`, `stop_i` and an offered byte (`in_valid_i`) is active. The bus front end can never raise two of these in the same cycle. The bench applies each of them as its own pulse on a separate clock, including the pulses it injects during the busy window. It changes `wp_i` only at a negedge, so the stop-time sample is unambiguous.

// File: rtl/pw_pkg.sv
package pw_pkg;
  typedef enum logic [1:0] {
    PW_IDLE = 2'd0,
    PW_ADDR = 2'd1,
    PW_DATA = 2'd2,
    PW_BUSY = 2'd3
  } pw_state_e;
endpackage

// File: rtl/pw_page_buffer.sv
module pw_page_buffer #(
  parameter int DATA_W = 8,
  parameter int SLOTS  = 16,
  localparam int IDX_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              wr_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_vld_o,
  output logic              any_vld_o
);
  logic [DATA_W-1:0] slot_q [SLOTS];
  logic [SLOTS-1:0]  vld_q;
  logic [SLOTS-1:0]  hit;

  // one-hot slot select for the incoming byte
  for (genvar g = 0; g < SLOTS; g++) begin : g_hit
    assign hit[g] = wr_i && (wr_idx_i == IDX_W'(g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int i = 0; i < SLOTS; i++) slot_q[i] <= '0;
    end else if (clr_i) begin
      vld_q <= '0;
    end else begin
      for (int i = 0; i < SLOTS; i++) begin
        if (hit[i]) begin
          slot_q[i] <= wr_data_i;
          vld_q[i]  <= 1'b1;
        end
      end
    end
  end

  assign rd_data_o = slot_q[rd_idx_i];
  assign rd_vld_o  = vld_q[rd_idx_i];
  assign any_vld_o = |vld_q;

  a_r6_flags_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (vld_q == '0));
endmodule

// File: rtl/pw_cycle_timer.sv
module pw_cycle_timer #(
  parameter int CYCLES = 40,
  localparam int CNT_W = $clog2(CYCLES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch_i,
  output logic             busy_o,
  output logic             last_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;

  assign last_o = busy_q && (cnt_q == CNT_W'(CYCLES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (launch_i) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else if (last_o) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (busy_q) begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign busy_o = busy_q;
  assign cnt_o  = cnt_q;

  a_r4_window_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> ($past(cnt_q) == CNT_W'(CYCLES - 1)));
  a_r9_no_relaunch: assert property (@(posedge clk) disable iff (!rst_n)
    launch_i |-> !busy_q);
endmodule

// File: rtl/pw_xfer_ctrl.sv
module pw_xfer_ctrl
  import pw_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int OFS_W  = 4,
  localparam int PAGE_W = ADDR_W - OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              addr_load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              in_valid_i,
  input  logic              stop_i,
  input  logic              wp_i,
  input  logic              any_vld_i,
  input  logic              last_i,
  output pw_state_e         state_o,
  output logic              in_ready_o,
  output logic              buf_clr_o,
  output logic              buf_wr_o,
  output logic [OFS_W-1:0]  buf_idx_o,
  output logic [PAGE_W-1:0] page_o,
  output logic              launch_o
);
  pw_state_e         state_q, state_d;
  logic [PAGE_W-1:0] page_q;
  logic [OFS_W-1:0]  ptr_q;
  logic              accept;

  assign in_ready_o = (state_q == PW_DATA);
  assign accept     = in_valid_i && in_ready_o;
  assign buf_clr_o  = start_i && (state_q != PW_BUSY);
  assign buf_wr_o   = accept && !start_i && !stop_i;
  assign buf_idx_o  = ptr_q;
  assign page_o     = page_q;
  assign launch_o   = (state_q == PW_DATA) && stop_i && !start_i
                      && any_vld_i && !wp_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PW_IDLE: if (start_i) state_d = PW_ADDR;
      PW_ADDR: begin
        if (start_i)          state_d = PW_ADDR;
        else if (stop_i)      state_d = PW_IDLE;
        else if (addr_load_i) state_d = PW_DATA;
      end
      PW_DATA: begin
        if (start_i)       state_d = PW_ADDR;
        else if (launch_o) state_d = PW_BUSY;
        else if (stop_i)   state_d = PW_IDLE;
      end
      PW_BUSY: if (last_i) state_d = PW_IDLE;
      default: state_d = PW_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PW_IDLE;
      page_q  <= '0;
      ptr_q   <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == PW_ADDR && addr_load_i && !start_i && !stop_i) begin
        page_q <= addr_i[ADDR_W-1:OFS_W];
        ptr_q  <= addr_i[OFS_W-1:0];
      end else if (buf_wr_o) begin
        ptr_q  <= ptr_q + 1'b1;
      end
    end
  end

  assign state_o = state_q;

  a_r4_launch: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PW_DATA && stop_i && !start_i && any_vld_i && !wp_i)
      |=> (state_q == PW_BUSY));
  a_r7_wp_discard: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PW_DATA && stop_i && !start_i && wp_i) |=> (state_q == PW_IDLE));
  a_r8_empty_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PW_DATA && stop_i && !start_i && !any_vld_i) |=> (state_q == PW_IDLE));
  a_r5_page_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PW_DATA) |=> $stable(page_q));
  a_r5_ptr_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_wr_o && ptr_q == '1) |=> (ptr_q == '0));
endmodule

// File: rtl/eeprom_page_commit.sv
module eeprom_page_commit
  import pw_pkg::*;
#(
  parameter int ADDR_W       = 11,
  parameter int DATA_W       = 8,
  parameter int PAGE_BYTES   = 16,
  parameter int WRITE_CYCLES = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              addr_load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic              stop_i,
  input  logic              wp_i,
  output logic              busy_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o
);
  localparam int OFS_W  = $clog2(PAGE_BYTES);
  localparam int PAGE_W = ADDR_W - OFS_W;
  localparam int CNT_W  = $clog2(WRITE_CYCLES);

  pw_state_e         state;
  logic              buf_clr, buf_wr, any_vld, rd_vld, launch, last;
  logic [OFS_W-1:0]  buf_idx, scan_idx;
  logic [PAGE_W-1:0] page;
  logic [DATA_W-1:0] rd_data;
  logic [CNT_W-1:0]  cnt;
  logic              scan_live;

  pw_xfer_ctrl #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .addr_load_i(addr_load_i),
    .addr_i(addr_i), .in_valid_i(in_valid_i), .stop_i(stop_i), .wp_i(wp_i),
    .any_vld_i(any_vld), .last_i(last), .state_o(state),
    .in_ready_o(in_ready_o), .buf_clr_o(buf_clr), .buf_wr_o(buf_wr),
    .buf_idx_o(buf_idx), .page_o(page), .launch_o(launch)
  );

  pw_page_buffer #(.DATA_W(DATA_W), .SLOTS(PAGE_BYTES)) u_buf (
    .clk(clk), .rst_n(rst_n), .clr_i(buf_clr), .wr_i(buf_wr),
    .wr_idx_i(buf_idx), .wr_data_i(in_data_i), .rd_idx_i(scan_idx),
    .rd_data_o(rd_data), .rd_vld_o(rd_vld), .any_vld_o(any_vld)
  );

  pw_cycle_timer #(.CYCLES(WRITE_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .launch_i(launch), .busy_o(busy_o),
    .last_o(last), .cnt_o(cnt)
  );

  // the first PAGE_BYTES cycles of the window scan the slots in order
  assign scan_idx    = cnt[OFS_W-1:0];
  assign scan_live   = busy_o && (cnt < CNT_W'(PAGE_BYTES));
  assign mem_we_o    = scan_live && rd_vld;
  assign mem_addr_o  = {page, scan_idx};
  assign mem_wdata_o = rd_data;

  a_r9_no_ready_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !in_ready_o);
  a_r4_busy_state: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (state == PW_BUSY));
  a_r3_no_write_collecting: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PW_DATA) |-> !mem_we_o);
endmodule

// File: tb/tb_eeprom_page_commit.sv
module tb_eeprom_page_commit;
  localparam int CLK_PERIOD = 10;
  localparam int W  = 40;
  localparam int NB = 2048;

  logic clk = 0, rst_n = 0;
  logic start_i = 0, addr_load_i = 0, in_valid_i = 0, stop_i = 0, wp_i = 0;
  logic [10:0] addr_i = '0;
  logic [7:0]  in_data_i = '0;
  logic in_ready_o, busy_o, mem_we_o;
  logic [10:0] mem_addr_o;
  logic [7:0]  mem_wdata_o;

  eeprom_page_commit #(.WRITE_CYCLES(W)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .addr_load_i(addr_load_i),
    .addr_i(addr_i), .in_valid_i(in_valid_i), .in_ready_o(in_ready_o),
    .in_data_i(in_data_i), .stop_i(stop_i), .wp_i(wp_i), .busy_o(busy_o),
    .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int compared = 0, mismatched = 0;
  bit done = 0;
  logic [7:0] mem_m [NB];
  logic [7:0] gold  [NB];
  logic [6:0] t_page;
  logic [3:0] t_ptr;
  logic [7:0] t_buf [16];
  logic [15:0] t_vld;

  function automatic logic [10:0] slot_addr(logic [6:0] pg, int idx);
    return {pg, 4'(idx)};
  endfunction
  function automatic int exp_window(logic [15:0] vld, logic wp);
    return ((vld != 0) && !wp) ? W : 0;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic do_start();
    start_i = 1; tick(); start_i = 0;
    t_vld = '0;
  endtask

  task automatic do_addr(logic [10:0] a);
    addr_load_i = 1; addr_i = a; tick(); addr_load_i = 0;
    t_page = a[10:4]; t_ptr = a[3:0];
  endtask

  task automatic do_byte(logic [7:0] d);
    in_valid_i = 1; in_data_i = d; #1;
    check(in_ready_o === 1'b1, "R2", "ready when addressed", int'(in_ready_o), 1);
    tick(); in_valid_i = 0;
    t_buf[t_ptr] = d; t_vld[t_ptr] = 1'b1; t_ptr = t_ptr + 1'b1;
    #1;
    check(mem_we_o === 1'b0 && busy_o === 1'b0, "R3", "no write while collecting",
          int'(mem_we_o), 0);
  endtask

  // offer a byte that must be refused
  task automatic try_byte(string req);
    in_valid_i = 1; in_data_i = 8'hEE; #1;
    check(in_ready_o === 1'b0, req, "ready must be low", int'(in_ready_o), 0);
    tick(); in_valid_i = 0;
  endtask

  task automatic do_stop(logic wp, bit noisy, bit wp_flip, string req);
    int c, exp_w, diffs;
    bit slot_ok;
    exp_w = exp_window(t_vld, wp);
    wp_i = wp; stop_i = 1; tick(); stop_i = 0;
    if (exp_w != 0)
      for (int i = 0; i < 16; i++) if (t_vld[i]) gold[slot_addr(t_page, i)] = t_buf[i];
    c = 0; slot_ok = 1;
    while (busy_o === 1'b1 && c < W + 8) begin
      if (mem_we_o === 1'b1) begin
        if (mem_addr_o[3:0] != 4'(c) || mem_addr_o[10:4] != t_page || c > 15)
          slot_ok = 0;
        mem_m[mem_addr_o] = mem_wdata_o;
      end
      start_i     = noisy && (c == 5);
      addr_load_i = noisy && (c == 7);
      addr_i      = 11'h000;
      in_valid_i  = noisy && (c == 9);
      stop_i      = noisy && (c == 11);
      if (wp_flip && c == 2) wp_i = ~wp_i;
      if (noisy && c == 9) begin
        #1;
        check(in_ready_o === 1'b0, "R9", "ready low in window", int'(in_ready_o), 0);
      end
      tick(); c++;
    end
    start_i = 0; addr_load_i = 0; in_valid_i = 0; stop_i = 0; wp_i = 0;
    check(c == exp_w, (exp_w == 0) ? req : "R4", "busy window length", c, exp_w);
    check(slot_ok, "R4", "slot i written in window cycle i", int'(slot_ok), 1);
    diffs = 0;
    for (int i = 0; i < NB; i++) if (mem_m[i] !== gold[i]) diffs++;
    check(diffs == 0, req, "array contents", diffs, 0);
  endtask

  task automatic xfer(logic [10:0] a, int n, logic wp, bit noisy, string req);
    do_start(); do_addr(a);
    for (int i = 0; i < n; i++) do_byte(8'($urandom));
    do_stop(wp, noisy, 0, req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      compared++; mismatched++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < NB; i++) begin mem_m[i] = 8'h00; gold[i] = 8'h00; end
    t_vld = '0; t_page = '0; t_ptr = '0;
    for (int i = 0; i < 16; i++) t_buf[i] = '0;
    repeat (3) tick();
    rst_n = 1; tick(); #1;
    check(busy_o === 0 && in_ready_o === 0 && mem_we_o === 0, "R1", "reset outputs",
          int'(busy_o) + int'(in_ready_o) + int'(mem_we_o), 0);

    // R2: idle and before address, bytes are refused
    try_byte("R2");
    do_start(); try_byte("R2");
    do_addr(11'h123); do_byte(8'h5A);
    do_stop(0, 0, 0, "R4");                       // single byte write

    xfer(11'h240, 16, 0, 0, "R4");                // full page
    xfer(11'h31D, 7, 0, 0, "R5");                 // offset 13 wraps to 3
    xfer(11'h400, 20, 0, 0, "R5");                // last bytes overwrite 0..3
    xfer(11'h555, 0, 0, 0, "R8");                 // address only
    do_start(); do_stop(0, 0, 0, "R8");           // no address at all
    xfer(11'h600, 5, 1, 0, "R7");                 // WP high discards

    // R7: WP high while loading, low at stop -> commit
    do_start(); do_addr(11'h6A0); wp_i = 1;
    do_byte(8'h11); do_byte(8'h22); wp_i = 0;
    do_stop(0, 0, 0, "R7");
    // R7: WP raised during the window has no effect
    do_start(); do_addr(11'h6B0); do_byte(8'h33); do_byte(8'h44);
    do_stop(0, 0, 1, "R7");

    // R6: repeated start throws away the first bytes
    do_start(); do_addr(11'h700);
    for (int i = 0; i < 6; i++) do_byte(8'($urandom));
    do_start(); do_addr(11'h702); do_byte(8'hC3);
    do_stop(0, 0, 0, "R6");

    // R9: pulses during the window ignored, no address without new start
    do_start(); do_addr(11'h7F0); do_byte(8'h99);
    do_stop(0, 1, 0, "R9");
    do_addr(11'h010); try_byte("R9");
    xfer(11'h010, 3, 0, 0, "R9");

    for (int k = 0; k < 30; k++) begin
      logic [10:0] a;
      int n;
      logic wp;
      a  = 11'($urandom % NB);
      n  = $urandom % 21;
      wp = (($urandom % 5) == 0);
      if (($urandom % 6) == 0) begin
        do_start(); do_addr(11'($urandom % NB));
        for (int i = 0; i < 3; i++) do_byte(8'($urandom));
      end
      xfer(a, n, wp, (($urandom % 4) == 0), (n == 0) ? "R8" : (wp ? "R7" : "R6"));
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule